// File: doc/BRIEF.md
# Byte-Lane Memory Bank Decoder

This block sits between a processor core that issues byte and word transfers on a 20-bit address space and a 16-bit data path built from two 8-bit memory banks. The even bank holds every byte whose address ends in 0 and connects to data bits 7:0. The odd bank holds every byte whose address ends in 1 and connects to data bits 15:8. For each request the block runs one or two bus cycles. In each cycle it drives the bank address, an active-low high-byte enable and the address LSB. It also raises exactly one of four strobes (memory read, memory write, I/O read, I/O write) and asserts a chip select for each bank lane that falls inside a mapped region.

Write data is placed on the lanes that the cycle uses. Read data is gathered from those lanes into a right-justified result. A word at an odd address is split into two ordered cycles. The first cycle carries the low byte on the high lane. The second cycle, at the next address, carries the high byte on the low lane. The default map holds two regions: 8 KB of RAM at 00000H (region 0) and 4 KB of ROM at 80000H (region 1).

Top module: `bank_decoder`

## Requirements
- R1: In every bus cycle exactly one of memRd, memWr, ioRd, ioWr is high. It is chosen by reqMem (1 = memory) and reqWrite (1 = write). All four are low between cycles.
- R2: A byte request at an even address takes one cycle with busBheN=1 and busA0=0. Write data is byte 0 of reqWdata on busWdata[7:0], with busWdataEn=2'b01. Read data is busRdata[7:0] returned in rspData[7:0], and rspData[15:8] is 0.
- R3: A word request at an even address takes one cycle with busBheN=0 and busA0=0. Both lanes are enabled and busWdata equals reqWdata. rspData is busRdata.
- R4: A byte request at an odd address takes one cycle with busBheN=0 and busA0=1. Write data is byte 0 of reqWdata on busWdata[15:8], with busWdataEn=2'b10. Read data is busRdata[15:8] returned in rspData[7:0].
- R5: A word request at an odd address A takes two cycles in order. Cycle 1 is at A with busBheN=0, busA0=1, and reqWdata[7:0] on busWdata[15:8]. Cycle 2 is at A+1 with busBheN=1, busA0=0, and reqWdata[15:8] on busWdata[7:0]. A read returns {cycle-2 low lane, cycle-1 high lane}.
- R6: bankAddr equals bits 19:1 of the byte address of the current cycle. For cycle 2 of a split word, that address is A+1.
- R7: Memory cycles at 00000H-01FFFH assert csEven[0] and/or csOdd[0]. Memory cycles at 80000H-80FFFH assert csEven[1] and/or csOdd[1]. csEven is set when busA0=0, csOdd when busBheN=0.
- R8: A memory cycle outside every region asserts no chip select, and its read lanes give 0 in rspData. This holds per cycle, so a split word that crosses a region end selects only in its mapped half.
- R9: I/O cycles never assert a chip select. They use the same lane rules, and their read data is returned like memory data.
- R10: reqReady is high only when no bus cycle is running. A request is taken at a clock edge with reqValid and reqReady both high. Its first cycle runs in the next clock, and reqReady stays low for 1 clock (2 for a split word). A read raises rspValid for one clock, during its last cycle.
- R11: While and after reset, reqReady is 1 and no strobe, chip select or write-lane enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request can be taken |
| reqAddr | input | 20 | Byte address of request |
| reqWord | input | 1 | 1 = 16-bit transfer, 0 = byte |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMem | input | 1 | 1 = memory space, 0 = I/O space |
| reqWdata | input | 16 | Write data, right-justified |
| rspValid | output | 1 | Read result valid this clock |
| rspData | output | 16 | Read result, right-justified |
| bankAddr | output | 19 | Address inside each bank |
| busBheN | output | 1 | Active-low high-lane enable |
| busA0 | output | 1 | Address LSB, 0 enables low lane |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| ioRd | output | 1 | I/O read strobe |
| ioWr | output | 1 | I/O write strobe |
| csEven | output | 2 | Per-region even-bank select |
| csOdd | output | 2 | Per-region odd-bank select |
| busWdata | output | 16 | Lane-placed write data |
| busWdataEn | output | 2 | Per-lane write drive enable |
| busRdata | input | 16 | Data returned by banks or I/O |

## Verification
The bench targets odd-address words. A design that swaps the two bytes, skips the second cycle, or reuses address A instead of A+1 would return garbled words and show a wrong bankAddr or lane pattern. The bench fills the unused lane of the bus model with a junk value, so a design that fails to mask that lane leaks the junk into rspData. Words that straddle the end of the RAM and ROM regions check that the decode is made per cycle: an incorrect design selects a bank in the unmapped half or loses the mapped byte. I/O requests at both parities check that I/O never raises a chip select and never shares a strobe with a memory cycle.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND} phaseT;

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic load;       // request taken this edge
    logic active;     // a bus cycle runs this clock
    logic second;     // second half of a split word
    logic word;
    logic write;
    logic mem;
  } busCtrlT;
endpackage

// File: rtl/bank_ctl.sv
module bank_ctl
  import bank_dec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqAddrLsb,
  input  logic    reqWord,
  input  logic    reqWrite,
  input  logic    reqMem,
  output logic    reqReady,
  output busCtrlT ctrl,
  output logic    memRd,
  output logic    memWr,
  output logic    ioRd,
  output logic    ioWr,
  output logic    rspValid
);
  phaseT phaseQ;
  logic  wordQ, writeQ, memQ, oddQ;
  logic  accept, active, splitting;

  assign reqReady  = (phaseQ == PH_IDLE);
  assign accept    = reqValid && reqReady;
  assign active    = (phaseQ != PH_IDLE);
  assign splitting = (phaseQ == PH_FIRST) && wordQ && oddQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      wordQ  <= 1'b0;
      writeQ <= 1'b0;
      memQ   <= 1'b0;
      oddQ   <= 1'b0;
    end else begin
      unique case (phaseQ)
        PH_IDLE: if (accept) begin
          phaseQ <= PH_FIRST;
          wordQ  <= reqWord;
          writeQ <= reqWrite;
          memQ   <= reqMem;
          oddQ   <= reqAddrLsb;
        end
        PH_FIRST:  phaseQ <= splitting ? PH_SECOND : PH_IDLE;
        PH_SECOND: phaseQ <= PH_IDLE;
        default:   phaseQ <= PH_IDLE;
      endcase
    end
  end

  assign ctrl.load   = accept;
  assign ctrl.active = active;
  assign ctrl.second = (phaseQ == PH_SECOND);
  assign ctrl.word   = wordQ;
  assign ctrl.write  = writeQ;
  assign ctrl.mem    = memQ;

  assign memRd    = active &&  memQ && !writeQ;
  assign memWr    = active &&  memQ &&  writeQ;
  assign ioRd     = active && !memQ && !writeQ;
  assign ioWr     = active && !memQ &&  writeQ;
  assign rspValid = active && !splitting && !writeQ;

  // R1: strobes exclusive, and quiet while idle
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, memWr, ioRd, ioWr}));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !(memRd || memWr || ioRd || ioWr));
  // R10: after the last read cycle the block is ready again
  a_r10_rsp_then_ready: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);
  // R5: a split word keeps its direction across both halves
  a_r5_split_then_second: assert property (@(posedge clk) disable iff (!rstN)
    splitting |=> (ctrl.second && $stable(writeQ) && $stable(memQ)));
endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import bank_dec_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int LANE_W  = 8,
  parameter int NUM_REG = 2,
  parameter logic [NUM_REG-1:0][ADDR_W-1:0] REG_BASE = {20'h80000, 20'h00000},
  parameter logic [NUM_REG-1:0][7:0]        REG_SPAN = {8'd12, 8'd13},
  localparam int DATA_W = 2 * LANE_W,
  localparam int BANK_W = ADDR_W - 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  busCtrlT            ctrl,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic [BANK_W-1:0]  bankAddr,
  output logic               busBheN,
  output logic               busA0,
  output logic [NUM_REG-1:0] csEven,
  output logic [NUM_REG-1:0] csOdd,
  output logic [DATA_W-1:0]  busWdata,
  output logic [1:0]         busWdataEn,
  input  logic [DATA_W-1:0]  busRdata,
  output logic [DATA_W-1:0]  rspData
);
  logic [ADDR_W-1:0]       addrQ, curAddr;
  logic [DATA_W-1:0]       wdataQ;
  logic [LANE_W-1:0]       lowByteQ;
  logic [1:0]              laneOn;
  logic [1:0][LANE_W-1:0]  laneData;
  logic [NUM_REG-1:0]      hit;
  logic                    mapped;

  assign curAddr  = ctrl.second ? addrQ + ADDR_W'(1) : addrQ;
  assign bankAddr = curAddr[ADDR_W-1:1];
  assign busA0    = curAddr[0];
  assign busBheN  = !(ctrl.active && ((ctrl.word && !ctrl.second) || curAddr[0]));
  assign laneOn[0] = ctrl.active && !curAddr[0];
  assign laneOn[1] = ctrl.active && !busBheN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      lowByteQ <= '0;
    end else begin
      if (ctrl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctrl.active && !ctrl.second && ctrl.word && curAddr[0])
        lowByteQ <= laneData[1];
    end
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_region
    localparam int SPAN = int'(REG_SPAN[r]);
    assign hit[r]    = (curAddr >> SPAN) == (REG_BASE[r] >> SPAN);
    assign csEven[r] = ctrl.mem && hit[r] && laneOn[0];
    assign csOdd[r]  = ctrl.mem && hit[r] && laneOn[1];
  end

  assign mapped = ctrl.mem ? (|hit) : 1'b1;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign laneData[g]   = (laneOn[g] && mapped) ? busRdata[g*LANE_W +: LANE_W] : '0;
    assign busWdataEn[g] = laneOn[g] && ctrl.write;
  end

  assign busWdata[LANE_W-1:0]      = ctrl.second ? wdataQ[DATA_W-1:LANE_W] : wdataQ[LANE_W-1:0];
  assign busWdata[DATA_W-1:LANE_W] = curAddr[0]  ? wdataQ[LANE_W-1:0]      : wdataQ[DATA_W-1:LANE_W];

  always_comb begin
    if (ctrl.second)                  rspData = {laneData[0], lowByteQ};
    else if (ctrl.word && !curAddr[0]) rspData = {laneData[1], laneData[0]};
    else if (curAddr[0])              rspData = {{LANE_W{1'b0}}, laneData[1]};
    else                              rspData = {{LANE_W{1'b0}}, laneData[0]};
  end

  // R5: second half of a split word uses only the low lane
  a_r5_second_lane: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.second |-> (busBheN && !busA0));
  // R3: even word opens both lanes
  a_r3_word_both: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && ctrl.word && !ctrl.second && !busA0) |-> !busBheN);
  // R8/R9: selects only in an active memory cycle
  a_r8_cs_needs_mem: assert property (@(posedge clk) disable iff (!rstN)
    (|{csEven, csOdd}) |-> (ctrl.active && ctrl.mem));
  // R7: at most one region per lane
  a_r7_one_region: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csEven) && $onehot0(csOdd));
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_dec_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int LANE_W  = 8,
  parameter int NUM_REG = 2,
  parameter logic [NUM_REG-1:0][ADDR_W-1:0] REG_BASE = {20'h80000, 20'h00000},
  parameter logic [NUM_REG-1:0][7:0]        REG_SPAN = {8'd12, 8'd13},
  localparam int DATA_W = 2 * LANE_W,
  localparam int BANK_W = ADDR_W - 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWord,
  input  logic               reqWrite,
  input  logic               reqMem,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData,
  output logic [BANK_W-1:0]  bankAddr,
  output logic               busBheN,
  output logic               busA0,
  output logic               memRd,
  output logic               memWr,
  output logic               ioRd,
  output logic               ioWr,
  output logic [NUM_REG-1:0] csEven,
  output logic [NUM_REG-1:0] csOdd,
  output logic [DATA_W-1:0]  busWdata,
  output logic [1:0]         busWdataEn,
  input  logic [DATA_W-1:0]  busRdata
);
  busCtrlT ctrl;

  bank_ctl u_ctl (
    .clk, .rstN, .reqValid,
    .reqAddrLsb(reqAddr[0]),
    .reqWord, .reqWrite, .reqMem,
    .reqReady, .ctrl,
    .memRd, .memWr, .ioRd, .ioWr, .rspValid
  );

  bank_datapath #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .NUM_REG(NUM_REG),
    .REG_BASE(REG_BASE), .REG_SPAN(REG_SPAN)
  ) u_dp (
    .clk, .rstN, .ctrl, .reqAddr, .reqWdata,
    .bankAddr, .busBheN, .busA0, .csEven, .csOdd,
    .busWdata, .busWdataEn, .busRdata, .rspData
  );
endmodule

// File: tb/bank_decoder_bench.sv
module bank_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWord = 1'b0, reqWrite = 1'b0, reqMem = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady, rspValid, busBheN, busA0, memRd, memWr, ioRd, ioWr;
  logic [15:0] rspData, busWdata;
  logic [15:0] busRdata = 16'hDEAD;
  logic [18:0] bankAddr;
  logic [1:0]  csEven, csOdd, busWdataEn;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bank_decoder u_bank_decoder (
    .clk, .rstN, .reqValid, .reqReady, .reqAddr, .reqWord, .reqWrite, .reqMem,
    .reqWdata, .rspValid, .rspData, .bankAddr, .busBheN, .busA0,
    .memRd, .memWr, .ioRd, .ioWr, .csEven, .csOdd, .busWdata, .busWdataEn, .busRdata
  );

  typedef struct {
    logic [18:0] ba;
    logic        bhe, a0;
    logic [3:0]  stb;
    logic [1:0]  ce, co, we;
    logic [15:0] wd;
    string       tag;
  } cycT;
  typedef struct {
    logic [15:0] d;
    string       tag;
  } rspT;

  cycT cq[$];
  rspT rq[$];
  bit [7:0] refMem [int];   // expected contents by byte address
  bit [7:0] bankMem [int];  // bus model storage by region/lane/bank address

  function automatic int regionOf(input logic [19:0] a);
    if (a < 20'h02000) return 0;
    if (a[19:12] == 8'h80) return 1;
    return -1;
  endfunction

  function automatic logic [7:0] expByte(input logic [19:0] a, input logic mem);
    if (!mem) return a[0] ? 8'hC3 : 8'h3C;
    if (regionOf(a) < 0) return 8'h00;
    return refMem.exists(int'(a)) ? refMem[int'(a)] : 8'h00;
  endfunction

  task automatic expCycle(input logic [19:0] a, input logic bheN, input logic [15:0] wd,
                          input logic wr, input logic mem, input string tag);
    cycT c;
    int  r;
    c.ba  = a[19:1];
    c.bhe = bheN;
    c.a0  = a[0];
    c.stb = mem ? (wr ? 4'b0100 : 4'b1000) : (wr ? 4'b0001 : 4'b0010);
    c.ce  = '0;
    c.co  = '0;
    r = regionOf(a);
    if (mem && r >= 0) begin
      if (!a[0]) c.ce[r] = 1'b1;
      if (!bheN) c.co[r] = 1'b1;
    end
    c.we  = wr ? {!bheN, !a[0]} : 2'b00;
    c.wd  = wd;
    c.tag = tag;
    cq.push_back(c);
  endtask

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // Driver: predicts bus cycles and response, then performs the handshake
  task automatic issue(input logic [19:0] a, input logic word, input logic wr,
                       input logic mem, input logic [15:0] wd, input string tag);
    rspT rs;
    bit  split;
    int  n;
    split = word && a[0];
    if (!word) begin
      expCycle(a, !a[0], a[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]}, wr, mem, tag);
      rs.d = {8'h00, expByte(a, mem)};
    end else if (!a[0]) begin
      expCycle(a, 1'b0, wd, wr, mem, tag);
      rs.d = {expByte(a + 20'd1, mem), expByte(a, mem)};
    end else begin
      expCycle(a, 1'b0, {wd[7:0], 8'h00}, wr, mem, tag);
      expCycle(a + 20'd1, 1'b1, {8'h00, wd[15:8]}, wr, mem, tag);
      rs.d = {expByte(a + 20'd1, mem), expByte(a, mem)};
    end
    rs.tag = tag;
    if (!wr) rq.push_back(rs);
    if (wr && mem) begin
      if (regionOf(a) >= 0) refMem[int'(a)] = wd[7:0];
      if (word && regionOf(a + 20'd1) >= 0) refMem[int'(a + 20'd1)] = wd[15:8];
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWord = word; reqWrite = wr; reqMem = mem; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!reqReady) begin
      n++;
      @(negedge clk);
    end
    check(n == (split ? 2 : 1),
          $sformatf("R10 busy clocks for %s at %h: got %0d exp %0d", tag, a, n, split ? 2 : 1));
  endtask

  // Bus model: banks per region and lane, an I/O device, junk elsewhere
  always @(posedge clk) begin
    logic [15:0] d;
    #2;
    d = 16'hDEAD;
    for (int r = 0; r < 2; r++) begin
      if (memWr && csEven[r]) bankMem[r * (1 << 21) + int'(bankAddr)] = busWdata[7:0];
      if (memWr && csOdd[r])  bankMem[r * (1 << 21) + (1 << 20) + int'(bankAddr)] = busWdata[15:8];
      if (memRd && csEven[r])
        d[7:0] = bankMem.exists(r * (1 << 21) + int'(bankAddr)) ?
                 bankMem[r * (1 << 21) + int'(bankAddr)] : 8'h00;
      if (memRd && csOdd[r])
        d[15:8] = bankMem.exists(r * (1 << 21) + (1 << 20) + int'(bankAddr)) ?
                  bankMem[r * (1 << 21) + (1 << 20) + int'(bankAddr)] : 8'h00;
    end
    if (ioRd) d = 16'hC33C;
    busRdata = d;
  end

  // Monitor: compares every bus cycle and every response against the queues
  always @(negedge clk) begin
    if (rstN) begin
      if (memRd || memWr || ioRd || ioWr) begin
        if (cq.size() == 0) begin
          check(1'b0, $sformatf("R1 unexpected strobes %b exp none", {memRd, memWr, ioRd, ioWr}));
        end else begin
          cycT e;
          logic [15:0] m;
          e = cq.pop_front();
          m = {{8{e.we[1]}}, {8{e.we[0]}}};
          check(bankAddr == e.ba && busBheN == e.bhe && busA0 == e.a0 &&
                {memRd, memWr, ioRd, ioWr} == e.stb && csEven == e.ce && csOdd == e.co &&
                busWdataEn == e.we && (busWdata & m) == (e.wd & m),
                $sformatf("%s R1 R6 cycle: got ba=%h bhe=%b a0=%b stb=%b ce=%b co=%b we=%b wd=%h exp ba=%h bhe=%b a0=%b stb=%b ce=%b co=%b we=%b wd=%h",
                          e.tag, bankAddr, busBheN, busA0, {memRd, memWr, ioRd, ioWr}, csEven, csOdd,
                          busWdataEn, busWdata & m, e.ba, e.bhe, e.a0, e.stb, e.ce, e.co, e.we, e.wd & m));
        end
      end
      if (rspValid) begin
        if (rq.size() == 0) begin
          check(1'b0, $sformatf("R10 unexpected rspValid data %h exp none", rspData));
        end else begin
          rspT e;
          e = rq.pop_front();
          check(rspData == e.d, $sformatf("%s read data: got %h exp %h", e.tag, rspData, e.d));
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog expired: got hang exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && !(memRd || memWr || ioRd || ioWr) && csEven == 0 && csOdd == 0 && busWdataEn == 0,
          $sformatf("R11 in reset: got ready=%b stb=%b cs=%b%b we=%b exp 1 0000 0000 00",
                    reqReady, {memRd, memWr, ioRd, ioWr}, csEven, csOdd, busWdataEn));
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !(memRd || memWr || ioRd || ioWr) && csEven == 0 && csOdd == 0,
          $sformatf("R11 after reset: got ready=%b stb=%b exp 1 0000", reqReady, {memRd, memWr, ioRd, ioWr}));

    // RAM region, byte and word lanes
    issue(20'h00010, 1'b0, 1'b1, 1'b1, 16'h0011, "R2 R7");
    issue(20'h00011, 1'b0, 1'b1, 1'b1, 16'h0022, "R4 R7");
    issue(20'h00010, 1'b1, 1'b0, 1'b1, 16'h0000, "R3");
    issue(20'h00010, 1'b0, 1'b0, 1'b1, 16'h0000, "R2");
    issue(20'h00011, 1'b0, 1'b0, 1'b1, 16'h0000, "R4");
    issue(20'h00030, 1'b1, 1'b1, 1'b1, 16'h7788, "R3");
    issue(20'h00030, 1'b1, 1'b0, 1'b1, 16'h0000, "R3");
    // Split words
    issue(20'h00021, 1'b1, 1'b1, 1'b1, 16'hBBAA, "R5 R6");
    issue(20'h00021, 1'b1, 1'b0, 1'b1, 16'h0000, "R5 R6");
    issue(20'h00022, 1'b0, 1'b0, 1'b1, 16'h0000, "R5 R2");
    issue(20'h00020, 1'b1, 1'b0, 1'b1, 16'h0000, "R5 R3");
    // ROM region
    issue(20'h80100, 1'b1, 1'b1, 1'b1, 16'h1234, "R7");
    issue(20'h80101, 1'b0, 1'b0, 1'b1, 16'h0000, "R7 R4");
    issue(20'h80FFE, 1'b1, 1'b1, 1'b1, 16'h9A9B, "R7");
    // Unmapped and region-edge words
    issue(20'h40000, 1'b1, 1'b1, 1'b1, 16'hFFFF, "R8");
    issue(20'h40000, 1'b1, 1'b0, 1'b1, 16'h0000, "R8");
    issue(20'h01FFF, 1'b1, 1'b1, 1'b1, 16'h5566, "R8 R5");
    issue(20'h01FFF, 1'b1, 1'b0, 1'b1, 16'h0000, "R8 R5");
    issue(20'h80FFF, 1'b1, 1'b0, 1'b1, 16'h0000, "R8 R7");
    issue(20'h02000, 1'b0, 1'b0, 1'b1, 16'h0000, "R8");
    // I/O space
    issue(20'h00040, 1'b0, 1'b0, 1'b0, 16'h0000, "R9 R2");
    issue(20'h00041, 1'b0, 1'b0, 1'b0, 16'h0000, "R9 R4");
    issue(20'h00040, 1'b1, 1'b0, 1'b0, 16'h0000, "R9 R3");
    issue(20'h00041, 1'b1, 1'b0, 1'b0, 16'h0000, "R9 R5");
    issue(20'h00010, 1'b1, 1'b1, 1'b0, 16'h4455, "R9 R1");
    issue(20'h00013, 1'b1, 1'b1, 1'b0, 16'h6677, "R9 R5");
    // I/O write must not have touched RAM at 00010
    issue(20'h00010, 1'b1, 1'b0, 1'b1, 16'h0000, "R9 R3");

    repeat (4) @(negedge clk);
    check(cq.size() == 0, $sformatf("R1 bus cycles missing: got %0d left exp 0", cq.size()));
    check(rq.size() == 0, $sformatf("R10 responses missing: got %0d left exp 0", rq.size()));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule